// File: doc/BRIEF.md
# SIMD Lane Branch Divergence Controller

This block sits beside every processing element of a SIMD array. It decides, for each broadcast instruction, whether that element takes part. A central sequencer broadcasts a stream of instructions. Each instruction carries its own address, a jump destination and an operation code. Every lane keeps three pieces of state: a live bit, a restart address and a local condition bit. A lane that must not follow the current path writes down the address at which it should rejoin the stream and goes to sleep. It wakes again when that address comes up on the broadcast bus.

The choice between sleeping and staying live depends on two things: whether the jump's condition holds and which way the jump points. A jump points ahead when its own address is below its destination. Otherwise it points back, and a destination equal to the jump's address counts as back. The OR of all live bits goes back to the sequencer. The sequencer uses it to skip code that no lane would run and to leave loops once every lane has left.

The broadcast stream has a valid strobe only and no ready. The array never stalls the sequencer, and the array consumes every beat that has the strobe high in the cycle it is presented. The lane outputs and the OR output are plain status pins.

Top module: `simd_pe_array`

## Requirements
- R1: After reset every lane is live, every local condition bit is 0 and `any_active` is 1. With `instr_valid` low, no lane raises `pe_exec`.
- R2: `instr_op` encodings are 0 = ordinary instruction, 1 = compare, 2 = jump if the lane's condition bit is 1, and 3 = unconditional jump. For every valid beat, bit i of `pe_exec` is 1 in the same cycle if lane i is live.
- R3: A compare beat loads bit i of `pe_cmp_result` into lane i's condition bit, but only in lanes that execute the beat.
- R4: A satisfied jump whose `instr_addr` is below `instr_target` puts the lane to sleep in the next cycle, with its restart address set to `instr_target`.
- R5: An unsatisfied jump whose `instr_addr` is below `instr_target` leaves the lane live.
- R6: A satisfied jump whose `instr_addr` is at or above `instr_target` leaves the lane live.
- R7: An unsatisfied jump whose `instr_addr` is at or above `instr_target` puts the lane to sleep in the next cycle, with its restart address set to `instr_addr` + 1.
- R8: An unconditional jump behaves as a jump whose condition holds, whatever the lane's condition bit is.
- R9: A sleeping lane ignores every beat whose address differs from its restart address. Its `pe_exec` stays 0, and its condition bit, restart address and live bit keep their values.
- R10: A sleeping lane that sees a valid beat at its restart address raises `pe_exec` in that cycle. It executes that beat in full, jumps included, and is live in the next cycle unless that beat puts it back to sleep.
- R11: `any_active` is the OR of all `pe_active` bits.
- R12: A beat with `instr_valid` low changes no lane state and raises no `pe_exec`, even when its address matches a restart address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Broadcast beat strobe |
| instr_op | input | 2 | Operation code of the beat |
| instr_addr | input | AW | Address of the broadcast instruction |
| instr_target | input | AW | Jump destination of the beat |
| pe_cmp_result | input | N_PE | Per-lane compare outcome loaded on compare beats |
| pe_exec | output | N_PE | Per-lane execute enable for the current beat |
| pe_active | output | N_PE | Per-lane live bit |
| any_active | output | 1 | OR of all live bits |

## Verification
Several properties are checked on every cycle. The sleep-entry rules are checked for both jump directions, together with the restart address each one writes. A backward taken jump must leave the lane live. A sleeping lane must hold its state while no matching beat arrives, and a matching beat must raise the execute enable. A quiet, idle array must stay quiet. Other behaviours show up only in the bench's scenarios: the compare path gated by the live bit, several lanes leaving a loop one by one, a lane that wakes on a jump and goes straight back to sleep, and a destination equal to the jump's own address being treated as backward.

// File: rtl/simd_br_pkg.sv
package simd_br_pkg;
  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_CMP   = 2'd1,
    OP_JCOND = 2'd2,
    OP_JUMP  = 2'd3
  } br_op_e;
endpackage

// File: rtl/jump_decide.sv
module jump_decide #(
  parameter int AW = 8
) (
  input  logic          is_jump,
  input  logic          uncond,
  input  logic          cond,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] target,
  output logic          park,
  output logic [AW-1:0] restart
);
  logic ahead;
  logic taken;

  always_comb begin
    ahead   = pc < target;
    taken   = uncond | cond;
    // ahead + taken, or back + not taken, both leave the lane behind
    park    = is_jump & (ahead ? taken : ~taken);
    restart = ahead ? target : AW'(pc + 1'b1);
  end
endmodule

// File: rtl/pe_branch_lane.sv
module pe_branch_lane
  import simd_br_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  br_op_e        op,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] target,
  input  logic          cmp_bit,
  output logic          exec_en,
  output logic          af_o
);
  logic          af_q;
  logic          cond_q;
  logic [AW-1:0] tar_q;
  logic          wake;
  logic          live;
  logic          go;
  logic          park;
  logic [AW-1:0] restart;

  assign wake    = ~af_q & instr_valid & (pc == tar_q);
  assign live    = af_q | wake;
  assign go      = instr_valid & live;
  assign exec_en = go;
  assign af_o    = af_q;

  jump_decide #(.AW(AW)) u_decide (
    .is_jump (op == OP_JCOND || op == OP_JUMP),
    .uncond  (op == OP_JUMP),
    .cond    (cond_q),
    .pc      (pc),
    .target  (target),
    .park    (park),
    .restart (restart)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      af_q   <= 1'b1;
      cond_q <= 1'b0;
      tar_q  <= '0;
    end else if (go) begin
      if (op == OP_CMP) cond_q <= cmp_bit;
      if (park) begin
        af_q  <= 1'b0;
        tar_q <= restart;
      end else begin
        af_q  <= 1'b1;
      end
    end
  end

  // R4: forward taken jump parks at the destination
  p_fwd_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && ((op == OP_JCOND && cond_q) || op == OP_JUMP) && pc < target)
    |=> (!af_q && tar_q == $past(target)));

  // R7: backward not-taken jump parks at the following address
  p_bwd_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_JCOND && !cond_q && pc >= target)
    |=> (!af_q && tar_q == AW'($past(pc) + 1'b1)));

  // R6: backward unconditional jump keeps the lane live
  p_bwd_stay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_JUMP && pc >= target) |=> af_q);

  // R9: a sleeping lane with no matching beat holds its state
  p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!af_q && !(instr_valid && pc == tar_q))
    |=> (!af_q && $stable(tar_q) && $stable(cond_q)));

  // R10: a matching beat is executed by the sleeping lane
  p_wake_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!af_q && instr_valid && pc == tar_q) |-> exec_en);
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import simd_br_pkg::*;
#(
  parameter int N_PE = 4,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [1:0]      instr_op,
  input  logic [AW-1:0]   instr_addr,
  input  logic [AW-1:0]   instr_target,
  input  logic [N_PE-1:0] pe_cmp_result,
  output logic [N_PE-1:0] pe_exec,
  output logic [N_PE-1:0] pe_active,
  output logic            any_active
);
  br_op_e op_dec;
  assign op_dec = br_op_e'(instr_op);

  for (genvar i = 0; i < N_PE; i++) begin : g_lane
    pe_branch_lane #(.AW(AW)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .op          (op_dec),
      .pc          (instr_addr),
      .target      (instr_target),
      .cmp_bit     (pe_cmp_result[i]),
      .exec_en     (pe_exec[i]),
      .af_o        (pe_active[i])
    );
  end

  assign any_active = |pe_active;

  // R12: with every lane asleep and no beat, nothing can wake
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_active && !instr_valid) |=> !any_active);

  // R11: while the OR is low, no lane reports live
  p_or_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !any_active |-> $countones(pe_active) == 0);
endmodule

// File: tb/simd_pe_array_tb.sv
`timescale 1ns/1ps
module simd_pe_array_tb_top;
  localparam int N = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [1:0] instr_op = 2'd0;
  logic [AW-1:0] instr_addr = '0;
  logic [AW-1:0] instr_target = '0;
  logic [N-1:0] pe_cmp_result = '0;
  logic [N-1:0] pe_exec;
  logic [N-1:0] pe_active;
  logic any_active;

  always #2 clk = ~clk;

  simd_pe_array #(.N_PE(N), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
    .instr_addr(instr_addr), .instr_target(instr_target),
    .pe_cmp_result(pe_cmp_result), .pe_exec(pe_exec),
    .pe_active(pe_active), .any_active(any_active)
  );

  typedef struct {
    logic [N-1:0] ex;
    logic [N-1:0] af;
    logic         act;
    string        tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [N-1:0]  m_af;
  logic [N-1:0]  m_cond;
  logic [AW-1:0] m_tar [N];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act_v, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act_v, exp_v);
    end
  endtask

  // driver: applies one beat and pushes the expected outcome
  task automatic beat(input bit v, input logic [1:0] op, input int a,
                      input int t, input logic [N-1:0] c, input string tag);
    exp_t e;
    @(negedge clk);
    instr_valid = v; instr_op = op; instr_addr = AW'(a);
    instr_target = AW'(t); pe_cmp_result = c;
    for (int i = 0; i < N; i++) begin
      bit live;
      live = m_af[i] || (v && AW'(a) == m_tar[i]);
      e.ex[i] = v && live;
      if (v && live) begin
        if (op == 2'd1) m_cond[i] = c[i];
        if (op >= 2'd2) begin
          bit sat, fwd;
          sat = (op == 2'd3) || m_cond[i];
          fwd = a < t;
          if (fwd && sat) begin m_af[i] = 1'b0; m_tar[i] = AW'(t); end
          else if (!fwd && !sat) begin m_af[i] = 1'b0; m_tar[i] = AW'(a + 1); end
          else m_af[i] = 1'b1;
        end else m_af[i] = 1'b1;
      end
    end
    e.af = m_af; e.act = |m_af; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares the design against the queue head
  initial begin
    forever begin
      @(negedge clk); #1;
      if (q.size() > 0) begin
        check(pe_exec == q[0].ex, q[0].tag, "exec", pe_exec, q[0].ex);
        @(posedge clk); #1;
        check(pe_active == q[0].af, q[0].tag, "active", pe_active, q[0].af);
        check(any_active == q[0].act, "R11", "any_active", any_active, q[0].act);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_af = '1; m_cond = '0;
    for (int i = 0; i < N; i++) m_tar[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check(pe_active == 4'hf, "R1", "reset active", pe_active, 4'hf);
    check(any_active == 1'b1, "R1", "reset or", any_active, 1);
    check(pe_exec == 4'h0, "R1", "reset exec", pe_exec, 0);

    beat(1, 2'd0, 1, 0, 4'h0, "R2");
    beat(1, 2'd2, 2, 10, 4'h0, "R5");       // cond clear after reset
    beat(1, 2'd1, 3, 0, 4'b0101, "R3");
    beat(1, 2'd2, 4, 9, 4'h0, "R4");        // lanes 0,2 park at 9
    beat(1, 2'd0, 5, 0, 4'h0, "R9");
    beat(1, 2'd1, 6, 0, 4'b1111, "R9");     // sleepers ignore compare
    beat(0, 2'd3, 9, 40, 4'h0, "R12");      // idle beat at restart address
    beat(1, 2'd3, 7, 12, 4'h0, "R8");       // all park, OR low
    beat(1, 2'd0, 9, 0, 4'h0, "R10");       // lanes 0,2 wake
    beat(1, 2'd0, 12, 0, 4'h0, "R10");      // lanes 1,3 wake
    // loop exit one lane at a time
    beat(1, 2'd1, 13, 0, 4'b1100, "R3");
    beat(1, 2'd2, 14, 13, 4'h0, "R7");
    beat(1, 2'd1, 13, 0, 4'b1000, "R3");
    beat(1, 2'd2, 14, 13, 4'h0, "R6");
    beat(1, 2'd1, 13, 0, 4'b0000, "R3");
    beat(1, 2'd2, 14, 13, 4'h0, "R7");
    beat(1, 2'd0, 15, 0, 4'h0, "R10");
    // wake on a jump that parks again
    beat(1, 2'd1, 16, 0, 4'b0001, "R3");
    beat(1, 2'd2, 17, 20, 4'h0, "R4");
    beat(1, 2'd3, 20, 25, 4'h0, "R10");
    beat(0, 2'd0, 25, 0, 4'h0, "R12");
    beat(1, 2'd0, 25, 0, 4'h0, "R10");
    // backward unconditional and equal-address case
    beat(1, 2'd1, 29, 0, 4'b1110, "R3");
    beat(1, 2'd3, 30, 28, 4'h0, "R8");
    beat(1, 2'd2, 31, 31, 4'h0, "R7");
    beat(1, 2'd0, 32, 0, 4'h0, "R10");
    @(negedge clk); instr_valid = 1'b0;
    wait (q.size() == 0);
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule